// File: doc/BRIEF.md
# Synchronous Burst Static Memory

This block is a clocked static memory with a built-in four-beat burst sequencer, intended as a secondary-cache model. Every address, data-in and control input is sampled on the rising clock edge. Only the output-enable input acts without the clock. Read data leaves through one output register.

A burst opens when one of two address-status strobes is asserted. The first strobe belongs to the processor and the second to the cache controller. An advance input then steps the low two address bits, in linear or interleaved order. Holding advance inactive suspends the burst on its current word. Three chip enables decide selection. A global write input, a byte-write enable and one strobe per byte lane together decide between read and write. A sleep input powers the array down while it keeps its contents. After sleep, a short lockout ignores the address strobes and records any violation in a sticky flag.

Top module: `sbsram`

## Requirements
- R1: While `ce1_n` is high, a low `adsp_n` is ignored and any open burst carries on. If `adsc_n` is low with `ce1_n` high, the device is deselected and `dout_oe` is low after that edge.
- R2: `ce2` and `ce3_n` are looked at only on edges where an address strobe takes effect. `ce2` low or `ce3_n` high on such an edge deselects the device. Changes to them on other edges have no effect on an open burst.
- R3: A selected edge with `adsp_n` low always starts a read, whatever the write inputs are. On the next edge, write inputs with `adv_n` high write that same word.
- R4: A selected edge with `adsc_n` low and the processor strobe not taking effect starts a write if the write condition holds, and a read otherwise.
- R5: `gw_n` low writes every lane. Otherwise, `bwe_n` low lets each low `bw_n[i]` write lane i, which is bits 8i+7 to 8i. With `bwe_n` high, or with every `bw_n` bit high, the cycle is a read.
- R6: Each edge with `adv_n` low steps a 2-bit beat count, which wraps after four beats. The low address bits are base plus count modulo 4 when `burst_linear` is 1, and base XOR count when it is 0. The upper address bits stay fixed.
- R7: An edge with `adv_n` high in an open burst keeps the current address. A read returns the same word again. A write stores the new data with the lane strobes of that edge.
- R8: The word read on an edge is on `dout` after that edge, until the next edge. `dout_oe` is high only while `oe_n` is low and the last edge was a read. It is low after a write edge or an idle edge, and it follows `oe_n` without waiting for a clock.
- R9: While `zz` is high, no access takes place and `dout_oe` is low. Memory contents are kept through the sleep.
- R10: On the two edges after `zz` returns low, both address strobes are ignored. A strobe asserted on either of those edges sets `recovery_err`, which stays set until reset.
- R11: After reset, `dout_oe` and `recovery_err` are low and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_linear | input | 1 | 1 selects linear beat order, 0 selects interleaved order |
| zz | input | 1 | Sleep request |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable 1, active low; masks `adsp_n` |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | DW/8 | Per-lane write strobes, active low |
| oe_n | input | 1 | Output enable, active low, not clocked |
| addr | input | AW | Word address |
| din | input | DW | Write data |
| dout | output | DW | Registered read data |
| dout_oe | output | 1 | High when `dout` is to be driven onto the shared bus |
| recovery_err | output | 1 | Sticky flag for a strobe asserted during the post-sleep lockout |

## Verification
The bench builds the memory with `AW` = 6 and a 32-bit word. With 64 words, every word it relies on can be filled with a known pattern through writes first. The burst table can then start at base addresses whose upper bits differ, and it confirms that wrap-around stays inside one aligned group of four. A 32-bit word gives four lanes, so partial-lane writes can leave both lower and upper untouched bytes to compare.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    typedef enum logic [2:0] {
        CYC_IDLE,
        CYC_DESEL,
        CYC_SLEEP,
        CYC_BEGIN_RD,
        CYC_BEGIN_WR,
        CYC_NEXT,
        CYC_HOLD
    } cyc_e;

    localparam int BEAT_W = 2;

    // low address bits of a beat, given the start offset and the beat count
    function automatic logic [BEAT_W-1:0] beat_lsb(input logic [BEAT_W-1:0] base,
                                                   input logic [BEAT_W-1:0] cnt,
                                                   input logic              lin);
        return lin ? BEAT_W'(base + cnt) : (base ^ cnt);
    endfunction

endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode
    import sbsram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             zz,
    input  logic             locked,
    input  logic             active,
    input  logic             adsp_n,
    input  logic             adsc_n,
    input  logic             adv_n,
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output cyc_e             cyc,
    output logic [LANES-1:0] lane_we,
    output logic             wr
);

    logic p_go;
    logic chip_sel;

    // processor strobe only counts with chip enable 1 active
    assign p_go     = !adsp_n && !ce1_n;
    assign chip_sel = !ce1_n && ce2 && !ce3_n;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_we[i] = !gw_n || (!bwe_n && !bw_n[i]);
    end
    assign wr = |lane_we;

    always_comb begin
        cyc = CYC_IDLE;
        if (zz) begin
            cyc = CYC_SLEEP;
        end else if (locked) begin
            cyc = CYC_IDLE;
        end else if (p_go || !adsc_n) begin
            if (!chip_sel)
                cyc = CYC_DESEL;
            else if (p_go || !wr)
                cyc = CYC_BEGIN_RD;
            else
                cyc = CYC_BEGIN_WR;
        end else if (active) begin
            cyc = adv_n ? CYC_HOLD : CYC_NEXT;
        end
    end

endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst
    import sbsram_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic          clear,
    input  logic          lin,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] acc_addr,
    output logic          active
);

    logic [AW-1:0]     base_q, base_n;
    logic [BEAT_W-1:0] cnt_q, cnt_n;

    always_comb begin
        base_n = load ? addr_i : base_q;
        if (load)
            cnt_n = '0;
        else if (step)
            cnt_n = cnt_q + 1'b1;
        else
            cnt_n = cnt_q;
    end

    assign acc_addr = {base_n[AW-1:BEAT_W], beat_lsb(base_n[BEAT_W-1:0], cnt_n, lin)};

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
            active <= 1'b0;
        end else begin
            base_q <= base_n;
            cnt_q  <= cnt_n;
            if (load)
                active <= 1'b1;
            else if (clear)
                active <= 1'b0;
        end
    end

    // R6: stepping never disturbs the burst base
    a_r6_base_hold: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> $stable(base_q));

endmodule

// File: rtl/sbsram_power.sv
module sbsram_power #(
    parameter int REC_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic zz,
    input  logic adsp_n,
    input  logic adsc_n,
    output logic locked,
    output logic rec_err
);

    localparam int CW = $clog2(REC_CYC + 1);

    logic [CW-1:0] rec_q;
    logic          strobe_any;

    assign strobe_any = !adsp_n || !adsc_n;
    assign locked     = !zz && (rec_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q   <= '0;
            rec_err <= 1'b0;
        end else begin
            if (zz)
                rec_q <= CW'(REC_CYC);
            else if (rec_q != '0)
                rec_q <= rec_q - 1'b1;
            if (locked && strobe_any)
                rec_err <= 1'b1;
        end
    end

    // R10: a strobe inside the lockout raises the flag
    a_r10_flag_set: assert property (@(posedge clk) disable iff (rst)
        (locked && strobe_any) |=> rec_err);

    // R10: the flag holds until reset
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        rec_err |=> rec_err);

endmodule

// File: rtl/sbsram.sv
module sbsram
    import sbsram_pkg::*;
#(
    parameter int AW      = 10,
    parameter int DW      = 32,
    parameter int REC_CYC = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            burst_linear,
    input  logic            zz,
    input  logic            adsp_n,
    input  logic            adsc_n,
    input  logic            adv_n,
    input  logic            ce1_n,
    input  logic            ce2,
    input  logic            ce3_n,
    input  logic            gw_n,
    input  logic            bwe_n,
    input  logic [DW/8-1:0] bw_n,
    input  logic            oe_n,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   din,
    output logic [DW-1:0]   dout,
    output logic            dout_oe,
    output logic            recovery_err
);

    localparam int LANES = DW / 8;
    localparam int DEPTH = 1 << AW;

    cyc_e             cyc;
    logic [LANES-1:0] lane_we;
    logic             wr;
    logic             locked;
    logic             active;
    logic [AW-1:0]    acc;
    logic             do_write, do_read, in_burst;
    logic             rd_valid;
    logic [DW-1:0]    dout_q;
    logic [DW-1:0]    mem [DEPTH];

    sbsram_power #(.REC_CYC(REC_CYC)) u_power (
        .clk(clk), .rst(rst), .zz(zz), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .locked(locked), .rec_err(recovery_err)
    );

    sbsram_decode #(.LANES(LANES)) u_decode (
        .zz(zz), .locked(locked), .active(active), .adsp_n(adsp_n),
        .adsc_n(adsc_n), .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
        .cyc(cyc), .lane_we(lane_we), .wr(wr)
    );

    sbsram_burst #(.AW(AW)) u_burst (
        .clk(clk), .rst(rst),
        .load(cyc == CYC_BEGIN_RD || cyc == CYC_BEGIN_WR),
        .step(cyc == CYC_NEXT),
        .clear(cyc == CYC_DESEL || cyc == CYC_SLEEP),
        .lin(burst_linear), .addr_i(addr),
        .acc_addr(acc), .active(active)
    );

    assign in_burst = (cyc == CYC_NEXT) || (cyc == CYC_HOLD);
    assign do_write = !rst && ((cyc == CYC_BEGIN_WR) || (in_burst && wr));
    assign do_read  = (cyc == CYC_BEGIN_RD) || (in_burst && !wr);

    always_ff @(posedge clk) begin
        if (do_write) begin
            for (int i = 0; i < LANES; i++) begin
                if (lane_we[i])
                    mem[acc][i*8 +: 8] <= din[i*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            dout_q   <= '0;
        end else if (do_read) begin
            rd_valid <= 1'b1;
            dout_q   <= mem[acc];
        end else begin
            rd_valid <= 1'b0;
        end
    end

    assign dout    = dout_q;
    assign dout_oe = rd_valid && !oe_n && !zz;

    // R11: reset leaves the bus undriven and the flag clear
    a_r11_reset_quiet: assert property (@(posedge clk)
        rst |=> (!dout_oe && !recovery_err));

    // R1: controller strobe with chip enable 1 inactive deselects
    a_r1_desel: assert property (@(posedge clk) disable iff (rst)
        (ce1_n && !adsc_n && !zz && !locked) |=> !dout_oe);

    // R2: chip enable 2 low on an effective strobe deselects
    a_r2_ce2_desel: assert property (@(posedge clk) disable iff (rst)
        (((!adsp_n && !ce1_n) || !adsc_n) && !ce2 && !zz && !locked) |=> !dout_oe);

    // R8: a write edge leaves the bus undriven
    a_r8_write_quiet: assert property (@(posedge clk) disable iff (rst)
        do_write |=> !dout_oe);

    // R9: a sleep edge ends any driving
    a_r9_sleep_quiet: assert property (@(posedge clk) disable iff (rst)
        zz |=> !dout_oe);

endmodule

// File: tb/sbsram_tb.sv
module sbsram_tb;

    localparam int AW = 6;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          burst_linear, zz, adsp_n, adsc_n, adv_n;
    logic          ce1_n, ce2, ce3_n, gw_n, bwe_n, oe_n;
    logic [3:0]    bw_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          dout_oe, recovery_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sbsram #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst(rst), .burst_linear(burst_linear), .zz(zz),
        .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .ce1_n(ce1_n),
        .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
        .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
        .recovery_err(recovery_err)
    );

    // burst table: {linear, base[3:0], beat0, beat1, beat2, beat3}
    localparam logic [20:0] BURST_TAB [6] = '{
        {1'b1, 4'd1,  4'd1,  4'd2,  4'd3,  4'd0},
        {1'b0, 4'd1,  4'd1,  4'd0,  4'd3,  4'd2},
        {1'b0, 4'd6,  4'd6,  4'd7,  4'd4,  4'd5},
        {1'b0, 4'd11, 4'd11, 4'd10, 4'd9,  4'd8},
        {1'b1, 4'd7,  4'd7,  4'd4,  4'd5,  4'd6},
        {1'b1, 4'd14, 4'd14, 4'd15, 4'd12, 4'd13}
    };

    function automatic logic [31:0] pat(input int a);
        return 32'hA000_0000 | 32'(a);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
        ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
        gw_n = 1'b1; bwe_n = 1'b1; bw_n = 4'hF;
        oe_n = 1'b0; zz = 1'b0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic begin_read(input int a);
        adsp_n = 1'b0; addr = AW'(a);
        tick();
        adsp_n = 1'b1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        idle();
        burst_linear = 1'b1; rst = 1'b1; addr = '0; din = '0;
        tick(); tick();
        rst = 1'b0;
        tick();
        check("R11 reset oe", 32'(dout_oe), 32'd0);
        check("R11 reset err", 32'(recovery_err), 32'd0);

        // R4/R5: fill words 0..15 through controller-strobe global writes
        for (int a = 0; a < 16; a++) begin
            adsc_n = 1'b0; gw_n = 1'b0; addr = AW'(a); din = pat(a);
            tick();
            if (a == 0) check("R8 write edge not driven", 32'(dout_oe), 32'd0);
        end
        idle();

        // R6: burst order table walked by one loop
        for (int r = 0; r < 6; r++) begin
            logic [20:0] row;
            row = BURST_TAB[r];
            burst_linear = row[20];
            begin_read(int'(row[19:16]));
            check("R6 beat0", dout, pat(int'(row[15:12])));
            adv_n = 1'b0;
            tick(); check("R6 beat1", dout, pat(int'(row[11:8])));
            tick(); check("R6 beat2", dout, pat(int'(row[7:4])));
            tick(); check("R6 beat3", dout, pat(int'(row[3:0])));
            tick(); check("R6 wrap", dout, pat(int'(row[15:12])));
            adv_n = 1'b1;
        end
        burst_linear = 1'b1;

        // R7: suspended read repeats the word
        begin_read(5);
        tick();
        check("R7 suspend read", dout, pat(5));
        check("R8 oe driven", 32'(dout_oe), 32'd1);
        oe_n = 1'b1; #1;
        check("R8 oe high no drive", 32'(dout_oe), 32'd0);
        oe_n = 1'b0; #1;
        check("R8 oe low drive", 32'(dout_oe), 32'd1);

        // R3: processor strobe reads despite write inputs, then writes next edge
        adsp_n = 1'b0; addr = 6'd3; gw_n = 1'b0; din = 32'hDEAD_BEEF;
        tick();
        check("R3 forced read", dout, pat(3));
        adsp_n = 1'b1; adv_n = 1'b1; din = 32'h1234_5678;
        tick();
        check("R3 write edge quiet", 32'(dout_oe), 32'd0);
        gw_n = 1'b1;
        begin_read(3);
        check("R3 write landed", dout, 32'h1234_5678);

        // R5: lanes 0 and 2 only
        adsc_n = 1'b0; addr = 6'd4; bwe_n = 1'b0; bw_n = 4'b1010; din = 32'h1122_3344;
        tick();
        idle();
        begin_read(4);
        check("R5 partial lanes", dout, 32'hA022_0044);
        adsc_n = 1'b0; addr = 6'd4; bwe_n = 1'b0; bw_n = 4'hF; din = '0;
        tick();
        check("R5 all strobes high reads", dout, 32'hA022_0044);
        check("R4 read drives", 32'(dout_oe), 32'd1);
        idle();

        // R7: suspended write rewrites, advance moves on
        adsc_n = 1'b0; addr = 6'd8; gw_n = 1'b0; din = 32'h0000_00D1;
        tick();
        adsc_n = 1'b1; din = 32'h0000_00D2;
        tick();
        adv_n = 1'b0; din = 32'h0000_00D3;
        tick();
        idle();
        begin_read(8);
        check("R7 suspend write", dout, 32'h0000_00D2);
        begin_read(9);
        check("R7 advanced write", dout, 32'h0000_00D3);

        // R1: chip enable 1 masks the processor strobe
        begin_read(2);
        adsp_n = 1'b0; ce1_n = 1'b1; addr = 6'd12;
        tick();
        check("R1 masked strobe", dout, pat(2));
        check("R1 masked still driven", 32'(dout_oe), 32'd1);
        adsp_n = 1'b1; adsc_n = 1'b0;
        tick();
        check("R1 deselect", 32'(dout_oe), 32'd0);
        idle();
        tick();
        check("R1 stays idle", 32'(dout_oe), 32'd0);

        // R2: chip enables 2/3 sampled only with a strobe
        begin_read(0);
        ce2 = 1'b0; ce3_n = 1'b1; adv_n = 1'b0;
        tick();
        check("R2 ignored mid burst", dout, pat(1));
        adv_n = 1'b1; adsc_n = 1'b0;
        tick();
        check("R2 ce2 deselect", 32'(dout_oe), 32'd0);
        idle();
        ce3_n = 1'b1; adsp_n = 1'b0; addr = 6'd0;
        tick();
        check("R2 ce3 deselect", 32'(dout_oe), 32'd0);
        idle();

        // R9/R10: sleep, lockout and retention
        begin_read(10);
        check("R10 flag clear", 32'(recovery_err), 32'd0);
        zz = 1'b1;
        tick();
        check("R9 sleep quiet", 32'(dout_oe), 32'd0);
        tick();
        check("R9 sleep quiet 2", 32'(dout_oe), 32'd0);
        zz = 1'b0; adsp_n = 1'b0; addr = 6'd1;
        tick();
        check("R10 lockout edge 1", 32'(dout_oe), 32'd0);
        check("R10 flag set", 32'(recovery_err), 32'd1);
        tick();
        check("R10 lockout edge 2", 32'(dout_oe), 32'd0);
        tick();
        check("R9 retained", dout, pat(1));
        check("R10 flag sticky", 32'(recovery_err), 32'd1);
        idle();

        // R11: reset clears the flag
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        tick();
        check("R11 flag cleared", 32'(recovery_err), 32'd0);
        check("R11 bus quiet", 32'(dout_oe), 32'd0);

        done = 1'b1;
        report();
    end

endmodule